// File: doc/BRIEF.md
# Data-Ready Serial ADC Frame Reader

This block is the host side of a link to a three-wire serial delta-sigma converter. The wires are an active-low select, a serial clock and a data line. The converter has no separate ready pin. It reports a finished conversion by pulling the shared data line low while select is asserted. The reader watches for that edge and then drives a burst of serial clock pulses. It shifts in the frame MSB first, checks the padding nibble, and presents the 16-bit two's-complement sample with a one-cycle strobe.

Two further modes cover system use. In skip mode the reader clocks nothing after the ready edge. It waits for the data line to rise again at the end of the unread conversion, and pulses a multiplexer-advance output at that moment. That edge is the point of maximum throughput for switching an external input multiplexer. A sleep request parks the serial clock high and releases select for a bounded minimum time, which puts the converter to sleep. During normal reads the clock-high time stays well below that bound.

A watchdog is sized from the converter's fixed ratio of 612 oscillator cycles per output word. If no ready edge arrives within two word periods, it raises a timeout flag and returns the reader to waiting.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst` is high, `adc_cs_n` is 1, `adc_sclk` is 0 and all strobes are 0. In the first cycle after reset is released, `adc_cs_n` goes to 0.
- R2: No serial clock pulse is issued until the data line has been seen high and then low while select is low. With the line held high, `adc_sclk` stays 0.
- R3: A read issues exactly FRAME_BITS clock pulses. Each high and each low phase lasts `clk_div`+1 system cycles, with `clk_div` of at least 2. Outside sleep, the clock is never high for SLEEP_TICKS cycles.
- R4: The data bit is sampled on each falling clock edge, MSB first. The first FRAME_BITS-20 bits are flags and are ignored. The next 4 bits are padding, and the last 16 bits are the sample. A good frame gives a one-cycle `result_valid` with `result_data` equal to those 16 bits, read as two's complement.
- R5: If any padding bit is 1, `frame_error` pulses for one cycle instead of `result_valid`, and `result_data` keeps its previous value.
- R6: When `skip_read` is 1 at the ready edge, no clock pulses are issued. `mux_advance` pulses once, for one cycle, only after the data line rises again.
- R7: When `sleep_req` is 1 while waiting, `adc_sclk` and `adc_cs_n` are both held high for at least SLEEP_TICKS cycles, and until the request drops. Reads then resume.
- R8: Transitions on `adc_sdo` while `adc_cs_n` is high start no read and produce no strobe.
- R9: If no ready edge arrives within 2·612·SYS_PER_OSC cycles of waiting, `timeout` goes to 1 and the reader goes back to waiting. `timeout` clears at the next ready edge, and that read completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system cycles |
| skip_read | input | 1 | Skip the next word and time a multiplexer step |
| sleep_req | input | 1 | Hold the serial clock high to put the converter to sleep |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Converter data and ready line |
| result_valid | output | 1 | One-cycle strobe for a good word |
| result_data | output | 16 | Last good sample, two's complement |
| frame_error | output | 1 | One-cycle strobe for a word with nonzero padding |
| mux_advance | output | 1 | One-cycle pulse at the rising data edge in skip mode |
| timeout | output | 1 | No ready edge within two word periods; sticky until the next ready |

## Verification
The hardest case to reach from the ports is a line that toggles while select is high. The synchronizer still carries those samples for two cycles after select drops, and a stale low could then pass for a ready edge. The stimulus requests sleep and wiggles the data line throughout the sleep window. It leaves the line high, lets the reader wake, and confirms that no clock pulse or strobe follows. The watchdog window is reached by shrinking the oscillator-per-cycle parameter to 1 and idling for slightly more than two word periods.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int RD_DATA_BITS    = 16;
    localparam int RD_PAD_BITS     = 4;
    localparam int RD_WORD_BITS    = RD_PAD_BITS + RD_DATA_BITS;
    localparam int RD_OSC_PER_WORD = 612;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_SHIFT,
        ST_DONE,
        ST_SKIP,
        ST_SLEEP
    } rd_state_e;

    typedef struct packed {
        logic [RD_PAD_BITS-1:0]         pad;
        logic signed [RD_DATA_BITS-1:0] sample;
    } rd_word_t;

    function automatic rd_word_t split_word(input logic [RD_WORD_BITS-1:0] raw);
        return rd_word_t'(raw);
    endfunction

    function automatic logic pad_clean(input rd_word_t w);
        return (w.pad == '0);
    endfunction

endpackage

// File: rtl/adc_rd_sdo_mon.sv
// Two-stage synchronizer on the data line, with the select level
// delayed alongside so each sample carries its own validity.
module adc_rd_sdo_mon (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sdo,
    output logic qual_valid,
    output logic qual_level
);
    logic s1, s2, c1, c2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            c1 <= 1'b1;
            c2 <= 1'b1;
        end else begin
            s1 <= sdo;
            s2 <= s1;
            c1 <= cs_n;
            c2 <= c1;
        end
    end

    assign qual_valid = !c2;
    assign qual_level = s2;

endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fall_tick = run && (cnt == div) && sclk;

    a_r3_phase_bounded: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(div) && $past(run)) |-> (cnt <= div));

endmodule

// File: rtl/adc_rd_watchdog.sv
module adc_rd_watchdog #(
    parameter int LIMIT = 1224
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    input  logic clear,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign expire = count_en && !clear && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear || expire)
            cnt <= '0;
        else if (count_en)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int FRAME_BITS  = 24,
    parameter int DIV_W       = 8,
    parameter int SYS_PER_OSC = 4,
    parameter int SLEEP_TICKS = 4096
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DIV_W-1:0]               clk_div,
    input  logic                           skip_read,
    input  logic                           sleep_req,
    output logic                           adc_cs_n,
    output logic                           adc_sclk,
    input  logic                           adc_sdo,
    output logic                           result_valid,
    output logic signed [RD_DATA_BITS-1:0] result_data,
    output logic                           frame_error,
    output logic                           mux_advance,
    output logic                           timeout
);
    localparam int WORD_TICKS = RD_OSC_PER_WORD * SYS_PER_OSC;
    localparam int WD_LIMIT   = 2 * WORD_TICKS;
    localparam int BIT_W      = $clog2(FRAME_BITS + 1);
    localparam int SLP_W      = $clog2(SLEEP_TICKS + 1);

    rd_state_e             state, nxt;
    logic                  qual_valid, qual_level;
    logic                  gen_sclk, fall_tick, wd_exp;
    logic                  seen_high;
    logic [BIT_W-1:0]      bit_cnt;
    logic [RD_WORD_BITS-1:0] shreg;
    logic [SLP_W-1:0]      slp_cnt;
    logic                  ready_evt, rise_evt;
    rd_word_t              word;

    adc_rd_sdo_mon u_mon (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (adc_cs_n),
        .sdo        (adc_sdo),
        .qual_valid (qual_valid),
        .qual_level (qual_level)
    );

    adc_rd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (state == ST_SHIFT),
        .div       (clk_div),
        .sclk      (gen_sclk),
        .fall_tick (fall_tick)
    );

    adc_rd_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk      (clk),
        .rst      (rst),
        .count_en ((state == ST_WAIT) || (state == ST_SKIP)),
        .clear    (ready_evt),
        .expire   (wd_exp)
    );

    assign ready_evt = (state == ST_WAIT) && seen_high && qual_valid && !qual_level;
    assign rise_evt  = (state == ST_SKIP) && qual_valid && qual_level;
    assign adc_sclk  = gen_sclk || (state == ST_SLEEP);
    assign word      = split_word(shreg);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: begin
                if (wd_exp)         nxt = ST_WAIT;
                else if (sleep_req) nxt = ST_SLEEP;
                else if (ready_evt) nxt = skip_read ? ST_SKIP : ST_SHIFT;
            end
            ST_SHIFT: if (fall_tick && bit_cnt == BIT_W'(FRAME_BITS - 1)) nxt = ST_DONE;
            ST_DONE:  nxt = ST_WAIT;
            ST_SKIP:  if (wd_exp || rise_evt) nxt = ST_WAIT;
            ST_SLEEP: if (!sleep_req && slp_cnt == SLP_W'(SLEEP_TICKS)) nxt = ST_WAIT;
            default:  nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_WAIT;
            adc_cs_n     <= 1'b1;
            seen_high    <= 1'b0;
            bit_cnt      <= '0;
            shreg        <= '0;
            slp_cnt      <= '0;
            result_valid <= 1'b0;
            result_data  <= '0;
            frame_error  <= 1'b0;
            mux_advance  <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            state        <= nxt;
            adc_cs_n     <= (nxt == ST_SLEEP);
            result_valid <= 1'b0;
            frame_error  <= 1'b0;
            mux_advance  <= 1'b0;

            // history of the qualified line level for edge detection
            if (state == ST_WAIT && wd_exp)
                seen_high <= 1'b0;
            else if ((state == ST_WAIT || state == ST_SKIP) && qual_valid && qual_level)
                seen_high <= 1'b1;
            else if (state != ST_WAIT && state != ST_SKIP)
                seen_high <= 1'b0;

            if (state == ST_WAIT)
                bit_cnt <= '0;
            else if (state == ST_SHIFT && fall_tick) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[RD_WORD_BITS-2:0], qual_level};
            end

            if (state == ST_DONE) begin
                if (pad_clean(word)) begin
                    result_valid <= 1'b1;
                    result_data  <= word.sample;
                end else begin
                    frame_error  <= 1'b1;
                end
            end

            if (rise_evt && !wd_exp)
                mux_advance <= 1'b1;

            if (ready_evt)
                timeout <= 1'b0;
            else if (wd_exp)
                timeout <= 1'b1;

            if (state != ST_SLEEP)
                slp_cnt <= '0;
            else if (slp_cnt != SLP_W'(SLEEP_TICKS))
                slp_cnt <= slp_cnt + 1'b1;
        end
    end

    // clock-high run length outside sleep, kept for the sleep-bound check
    logic [SLP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst || !adc_sclk || state == ST_SLEEP)
            hi_cnt <= '0;
        else if (hi_cnt != SLP_W'(SLEEP_TICKS))
            hi_cnt <= hi_cnt + 1'b1;
    end

    a_r3_sclk_high_bounded: assert property (@(posedge clk) disable iff (rst)
        (state != ST_SLEEP) |-> (hi_cnt < SLP_W'(SLEEP_TICKS)));
    a_r1_cs_low_when_clocking: assert property (@(posedge clk) disable iff (rst)
        (adc_sclk && state != ST_SLEEP) |-> !adc_cs_n);
    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(result_valid && frame_error));
    a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result_data));
    a_r6_mux_without_clock: assert property (@(posedge clk) disable iff (rst)
        mux_advance |-> !adc_sclk);
    a_r7_sleep_releases_cs: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP) |-> (adc_cs_n && adc_sclk));
    a_r9_timeout_while_waiting: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> $past(state == ST_WAIT || state == ST_SKIP));

endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;

    localparam int FB    = 24;
    localparam int DW    = 4;
    localparam int SPO   = 1;
    localparam int ST    = 40;
    localparam int LIMIT = 2 * 612 * SPO;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, skip_read, sleep_req, adc_sdo;
    logic [DW-1:0] clk_div;
    logic          adc_cs_n, adc_sclk, result_valid, frame_error, mux_advance, timeout;
    logic signed [15:0] result_data;

    adc_frame_reader #(.FRAME_BITS(FB), .DIV_W(DW), .SYS_PER_OSC(SPO), .SLEEP_TICKS(ST)) dut (
        .clk(clk), .rst(rst), .clk_div(clk_div), .skip_read(skip_read), .sleep_req(sleep_req),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
        .result_valid(result_valid), .result_data(result_data), .frame_error(frame_error),
        .mux_advance(mux_advance), .timeout(timeout)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int          kind;   // 0 result, 1 frame error, 2 mux step, 3 timeout
        logic [15:0] data;
    } ev_t;
    ev_t exp_q[$];

    logic [15:0] last_good = 16'h0000;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // port monitor: clock activity and event scoreboard
    int   rises = 0, hi_run = 0, last_hi = 0, sleep_hi = 0, mux_cnt = 0, ev_cnt = 0;
    logic sclk_prev = 1'b0, to_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!adc_cs_n) begin
                if (adc_sclk && !sclk_prev) rises++;
                if (adc_sclk) hi_run++;
                else if (sclk_prev) begin last_hi = hi_run; hi_run = 0; end
            end
            if (adc_cs_n && adc_sclk) sleep_hi++;
            if (mux_advance) mux_cnt++;
            if (result_valid || frame_error || mux_advance || (timeout && !to_prev)) begin
                int k;
                ev_t e;
                ev_cnt++;
                k = result_valid ? 0 : frame_error ? 1 : mux_advance ? 2 : 3;
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected event kind", k, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(k == e.kind, "R4", "event kind", k, e.kind);
                    if (k == 0) chk(result_data == e.data, "R4", "result_data", int'(result_data), int'(signed'(e.data)));
                    if (k == 1) chk(result_data == e.data, "R5", "data held on error", int'(result_data), int'(signed'(e.data)));
                end
            end
        end
        sclk_prev = adc_cs_n ? 1'b0 : adc_sclk;
        to_prev   = timeout;
    end

    task automatic wait_rise();
        logic p;
        bit   got;
        p   = adc_sclk;
        got = 0;
        while (!got) begin
            @(negedge clk);
            got = adc_sclk && !p;
            p   = adc_sclk;
        end
    endtask

    // converter model plus expectation driver
    task automatic adc_read(input logic [3:0] flg, input logic [3:0] pad, input logic [15:0] d);
        logic [FB-1:0] f;
        int r0;
        ev_t e;
        f = {flg, pad, d};
        if (pad == 4'h0) begin e.kind = 0; e.data = d; last_good = d; end
        else begin e.kind = 1; e.data = last_good; end
        exp_q.push_back(e);
        r0 = rises;
        @(negedge clk) adc_sdo = 1'b0;
        for (int i = 0; i < FB; i++) begin
            wait_rise();
            adc_sdo = f[FB-1-i];
        end
        while (adc_sclk) @(negedge clk);
        @(negedge clk) adc_sdo = 1'b1;
        repeat (4) @(negedge clk);
        chk(rises - r0 == FB, "R3", "pulses per frame", rises - r0, FB);
        chk(last_hi == int'(clk_div) + 1, "R3", "high phase length", last_hi, int'(clk_div) + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0, m0, s0, e0;
        ev_t e;
        rst = 1'b1; adc_sdo = 1'b1; skip_read = 1'b0; sleep_req = 1'b0; clk_div = 4'd2;
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "cs_n in reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R1", "sclk in reset", adc_sclk, 0);
        chk(result_valid == 1'b0 && timeout == 1'b0, "R1", "strobes in reset", result_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n == 1'b0, "R1", "cs_n after reset", adc_cs_n, 0);

        // R2: line held high, no clocking
        r0 = rises;
        repeat (20) @(negedge clk);
        chk(rises == r0, "R2", "no clock without ready", rises - r0, 0);

        // R4: several sample patterns, sign corners included
        adc_read(4'hA, 4'h0, 16'h1234);
        adc_read(4'h0, 4'h0, 16'h8000);
        adc_read(4'hF, 4'h0, 16'hFFFF);
        adc_read(4'h5, 4'h0, 16'h7FFF);
        clk_div = 4'd5;
        adc_read(4'h3, 4'h0, 16'h0001);
        clk_div = 4'd2;

        // R5: nonzero padding discards the word
        adc_read(4'h0, 4'h4, 16'hDEAD);
        adc_read(4'h0, 4'h0, 16'h00FF);

        // R6: skip read, multiplexer step on the rising data edge
        skip_read = 1'b1;
        r0 = rises; m0 = mux_cnt;
        e.kind = 2; e.data = 16'h0; exp_q.push_back(e);
        @(negedge clk) adc_sdo = 1'b0;
        repeat (30) @(negedge clk);
        chk(rises == r0, "R6", "no clock in skip", rises - r0, 0);
        chk(mux_cnt == m0, "R6", "no step before rise", mux_cnt - m0, 0);
        adc_sdo = 1'b1;
        repeat (8) @(negedge clk);
        chk(mux_cnt == m0 + 1, "R6", "one step after rise", mux_cnt - m0, 1);
        skip_read = 1'b0;
        adc_read(4'h9, 4'h0, 16'hC3C3);

        // R7 and R8: sleep with the line wiggling while select is high
        s0 = sleep_hi; e0 = ev_cnt;
        sleep_req = 1'b1;
        while (!adc_cs_n) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            adc_sdo = 1'b0;
            repeat (2) @(negedge clk);
            adc_sdo = 1'b1;
            repeat (2) @(negedge clk);
        end
        sleep_req = 1'b0;
        while (adc_cs_n) @(negedge clk);
        chk(sleep_hi - s0 >= ST, "R7", "sleep high cycles", sleep_hi - s0, ST);
        r0 = rises;
        repeat (30) @(negedge clk);
        chk(rises == r0, "R8", "no clock from ignored line", rises - r0, 0);
        chk(ev_cnt == e0, "R8", "no strobe from ignored line", ev_cnt - e0, 0);
        adc_read(4'h1, 4'h0, 16'h4321);

        // R9: watchdog
        e.kind = 3; e.data = 16'h0; exp_q.push_back(e);
        repeat (LIMIT - 30) @(negedge clk);
        chk(timeout == 1'b0, "R9", "timeout too early", timeout, 0);
        repeat (60) @(negedge clk);
        chk(timeout == 1'b1, "R9", "timeout raised", timeout, 1);
        adc_read(4'h6, 4'h0, 16'h5A5A);
        chk(timeout == 1'b0, "R9", "timeout cleared by ready", timeout, 0);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "outstanding expected events", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule